// File: doc/BRIEF.md
# Serial Presence-Detect EEPROM Slave

This block is a two-wire serial slave in front of a 256-byte configuration memory, as found on a memory module. A fast system clock oversamples the serial clock and data lines. The block finds start and stop conditions on the filtered lines and matches the address byte against a fixed device-type nibble and three board strap pins. It acknowledges by pulling the data line low through an open-drain enable.

A master can store bytes at a word address it picks, read from the current internal pointer, set the pointer and then read (random read), or keep reading for as long as it acknowledges. The memory is a register array loaded with a fixed image at reset. A background scanner checks the stored checksum byte and reports the result on a flag. A write-protect pin blocks stores but not acknowledges. After a transfer that stored data, the block ignores its address for a set number of system clocks, which stands in for the programming time.

Top module: `spd_slave`

## Requirements
- R1: The address byte is acknowledged (data held low during the ninth clock) only when its bits 7..4 are 4'b1010 and bits 3..1 equal strap_i[2:0]. Otherwise the block does not acknowledge and keeps the data line released until the next start or stop.
- R2: In a transfer with bit 0 of the address byte equal to 0, the first byte after the address loads the word pointer. Each later byte is stored at the pointer, and the pointer then increments. Every byte is acknowledged.
- R3: The block changes its data line drive only while the filtered serial clock is low, so the line is stable through every clock-high phase.
- R4: A read (address bit 0 equal to 1) without a preceding pointer load returns the byte at the current pointer. The pointer always rests one past the last byte read or stored.
- R5: A random read (a write transfer carrying only the word address, a repeated start, then a read address byte) returns the byte at that word address.
- R6: While the master acknowledges each read byte, the block sends the byte at the next address. The pointer wraps from 255 to 0.
- R7: When the master does not acknowledge a read byte, the block releases the line and drives nothing until the next start or stop.
- R8: When wp_i is high, data bytes are still acknowledged and the pointer still advances, but the memory is left unchanged.
- R9: After a stop that ends a transfer in which at least one byte was stored, the address byte is not acknowledged for BUSY_CLKS system clocks. A transfer that stored nothing starts no busy time.
- R10: At reset, byte k holds (37*k+11) mod 256 for k in 0..62. Byte 63 holds the low 8 bits of the sum of bytes 0..62. Byte k holds k XOR 8'hA5 for k in 64..255.
- R11: csum_ok_o is low after reset until the first 64-clock scan completes. After that it reports whether byte 63 equals the low 8 bits of the sum of bytes 0..62, re-evaluated every 64 clocks.
- R12: A pulse one system clock wide on either line is filtered out and changes no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| strap_i | input | 3 | Board strap pins selecting this module's address |
| wp_i | input | 1 | Write protect; high blocks stores |
| sda_pull_o | output | 1 | Open-drain enable; high pulls the data line low |
| csum_ok_o | output | 1 | Stored checksum byte matches bytes 0..62 |

## Verification
The bench uses a read window that straddles address 255. A counter that saturated or stopped at the top would return the wrong byte after 8'hFF. It retries the address right after a stored write and again after the busy window, so a missing or stuck busy counter shows up as a wrong acknowledge. It also sends write-protected bytes and then reads them back, which catches a design that still stores or does not acknowledge them. Further runs cover a master that does not acknowledge, where a slave that kept driving would pull the line during the following clocks, and one-clock glitches on both lines in mid-byte, which an unfiltered front end would take as extra bits or a false start. A corrupted byte 10 must drop the checksum flag.

// File: rtl/spd_pkg.sv
package spd_pkg;

   localparam int CSUM_POS = 63;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_AACK,
      ST_WR,
      ST_WACK,
      ST_RD,
      ST_RACK,
      ST_WAIT
   } spd_state_e;

   // reset image of the configuration store
   function automatic logic [7:0] boot_byte(input int k);
      logic [7:0] s;
      if (k < CSUM_POS) return 8'((k * 37 + 11) % 256);
      if (k == CSUM_POS) begin
         s = 8'h00;
         for (int j = 0; j < CSUM_POS; j++) s = s + 8'((j * 37 + 11) % 256);
         return s;
      end
      return 8'(k % 256) ^ 8'hA5;
   endfunction

endpackage

// File: rtl/spd_line_filter.sv
module spd_line_filter #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_i,
   output logic filt_o
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("spd_line_filter: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic [2:0]             win_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '1;
         win_q  <= '1;
         filt_o <= 1'b1;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
         win_q  <= {win_q[1:0], sync_q[SYNC_STAGES-1]};
         filt_o <= (win_q[0] & win_q[1]) | (win_q[0] & win_q[2]) | (win_q[1] & win_q[2]);
      end
   end
endmodule

// File: rtl/spd_bus_events.sv
module spd_bus_events (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_f,
   input  logic sda_f,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_ev,
   output logic stop_ev
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_f;
         sda_q <= sda_f;
      end
   end

   assign scl_rise = scl_f & ~scl_q;
   assign scl_fall = ~scl_f & scl_q;
   assign start_ev = scl_f & scl_q & sda_q & ~sda_f;
   assign stop_ev  = scl_f & scl_q & ~sda_q & sda_f;
endmodule

// File: rtl/spd_store.sv
module spd_store
   import spd_pkg::*;
#(
   parameter int AW = 8,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata,
   output logic          csum_ok
);
   localparam int DEPTH = 1 << AW;
   localparam int IW    = $clog2(CSUM_POS + 1);

   if (DW != 8) begin : g_bad_dw
      $error("spd_store: DW must be 8");
   end
   if (CSUM_POS >= DEPTH) begin : g_bad_aw
      $error("spd_store: store too small for the checksum byte");
   end

   logic [DW-1:0] mem [DEPTH];
   logic [IW-1:0] scan_idx;
   logic [DW-1:0] scan_acc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= boot_byte(i);
      end else if (we) begin
         mem[waddr] <= wdata;
      end
   end

   assign rdata = mem[raddr];

   // one 8-bit adder walks the protected range, verdict once per pass
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scan_idx <= '0;
         scan_acc <= '0;
         csum_ok  <= 1'b0;
      end else if (scan_idx == IW'(CSUM_POS)) begin
         csum_ok  <= (scan_acc == mem[CSUM_POS]);
         scan_idx <= '0;
         scan_acc <= '0;
      end else begin
         scan_acc <= scan_acc + mem[scan_idx];
         scan_idx <= scan_idx + IW'(1);
      end
   end
endmodule

// File: rtl/spd_slave.sv
module spd_slave
   import spd_pkg::*;
#(
   parameter int         BUSY_CLKS   = 1000,
   parameter int         SYNC_STAGES = 2,
   parameter logic [3:0] TYPE_CODE   = 4'b1010
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   input  logic [2:0] strap_i,
   input  logic       wp_i,
   output logic       sda_pull_o,
   output logic       csum_ok_o
);
   localparam int BW = $clog2(BUSY_CLKS + 1);

   if (BUSY_CLKS < 1) begin : g_bad_busy
      $error("spd_slave: BUSY_CLKS must be at least 1");
   end

   // line conditioning, one filter per wire
   logic [1:0] raw_lines, filt_lines;
   assign raw_lines = {sda_i, scl_i};
   for (genvar g = 0; g < 2; g++) begin : g_line
      spd_line_filter #(.SYNC_STAGES(SYNC_STAGES)) u_filt (
         .clk(clk), .rst_n(rst_n), .raw_i(raw_lines[g]), .filt_o(filt_lines[g]));
   end

   logic scl_f, sda_f, scl_rise, scl_fall, start_ev, stop_ev;
   assign scl_f = filt_lines[0];
   assign sda_f = filt_lines[1];

   spd_bus_events u_ev (
      .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
      .scl_rise(scl_rise), .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev));

   spd_state_e  state;
   logic [3:0]  bitcnt;
   logic [7:0]  shreg, ptr, rdata;
   logic        rd_mode, first_wr, wrote, mack, pull, busy, mem_we;
   logic [BW-1:0] busy_cnt;

   assign busy   = (busy_cnt != '0);
   assign mem_we = (state == ST_WR) && scl_fall && (bitcnt == 4'd8) && !first_wr && !wp_i && !start_ev && !stop_ev;

   spd_store #(.AW(8), .DW(8)) u_store (
      .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(ptr), .wdata(shreg),
      .raddr(ptr), .rdata(rdata), .csum_ok(csum_ok_o));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         bitcnt   <= '0;
         shreg    <= '0;
         ptr      <= '0;
         rd_mode  <= 1'b0;
         first_wr <= 1'b0;
         wrote    <= 1'b0;
         mack     <= 1'b0;
         pull     <= 1'b0;
         busy_cnt <= '0;
      end else begin
         if (busy) busy_cnt <= busy_cnt - BW'(1);
         if (start_ev) begin
            state  <= ST_ADDR;
            bitcnt <= '0;
            pull   <= 1'b0;
         end else if (stop_ev) begin
            state <= ST_IDLE;
            pull  <= 1'b0;
            wrote <= 1'b0;
            if (wrote) busy_cnt <= BW'(BUSY_CLKS);
         end else begin
            unique case (state)
               ST_ADDR, ST_WR: begin
                  if (scl_rise) begin
                     shreg  <= {shreg[6:0], sda_f};
                     bitcnt <= bitcnt + 4'd1;
                  end else if (scl_fall && bitcnt == 4'd8) begin
                     if (state == ST_ADDR) begin
                        if (shreg[7:4] == TYPE_CODE && shreg[3:1] == strap_i && !busy) begin
                           pull    <= 1'b1;
                           rd_mode <= shreg[0];
                           state   <= ST_AACK;
                        end else begin
                           state <= ST_WAIT;
                        end
                     end else begin
                        pull  <= 1'b1;
                        state <= ST_WACK;
                        if (first_wr) begin
                           ptr      <= shreg;
                           first_wr <= 1'b0;
                        end else begin
                           ptr <= ptr + 8'd1;
                           if (!wp_i) wrote <= 1'b1;
                        end
                     end
                  end
               end
               ST_AACK, ST_RACK: begin
                  if (scl_rise) begin
                     mack <= ~sda_f;
                  end else if (scl_fall) begin
                     bitcnt <= '0;
                     if ((state == ST_AACK && rd_mode) || (state == ST_RACK && mack)) begin
                        shreg <= rdata;
                        pull  <= ~rdata[7];
                        ptr   <= ptr + 8'd1;
                        state <= ST_RD;
                     end else if (state == ST_AACK) begin
                        pull     <= 1'b0;
                        first_wr <= 1'b1;
                        state    <= ST_WR;
                     end else begin
                        state <= ST_WAIT;
                     end
                  end
               end
               ST_WACK: begin
                  if (scl_fall) begin
                     pull   <= 1'b0;
                     bitcnt <= '0;
                     state  <= ST_WR;
                  end
               end
               ST_RD: begin
                  if (scl_rise) begin
                     bitcnt <= bitcnt + 4'd1;
                  end else if (scl_fall) begin
                     if (bitcnt == 4'd8) begin
                        pull  <= 1'b0;
                        state <= ST_RACK;
                     end else begin
                        shreg <= {shreg[6:0], 1'b0};
                        pull  <= ~shreg[6];
                     end
                  end
               end
               default: pull <= 1'b0;
            endcase
         end
      end
   end

   assign sda_pull_o = pull;
endmodule

// File: rtl/spd_slave_chk.sv
module spd_slave_chk
   import spd_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       scl_f,
   input logic       stop_ev,
   input logic       pull,
   input logic       csum_ok,
   input logic       busy,
   input spd_state_e st,
   input logic [7:0] addr_byte,
   input logic [2:0] strap,
   input logic [3:0] type_code
);
   // R3: the line is only ever pulled while the clock is low
   p_pull_scl_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pull) |-> !scl_f);

   // R7: a stop always leaves the line released
   p_release_on_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      stop_ev |=> !pull);

   // R1: entering the address acknowledge needs a full match
   p_ack_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st == ST_AACK) |-> (addr_byte[7:4] == type_code && addr_byte[3:1] == strap));

   // R9: no address acknowledge while programming is in progress
   p_no_ack_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st == ST_AACK) |-> !$past(busy));

   // R11: the flag starts low when reset is released
   p_csum_low_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !csum_ok);
endmodule

bind spd_slave spd_slave_chk u_chk (
   .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .stop_ev(stop_ev), .pull(sda_pull_o),
   .csum_ok(csum_ok_o), .busy(busy), .st(state), .addr_byte(shreg),
   .strap(strap_i), .type_code(TYPE_CODE));

// File: tb/tb_spd_slave.sv
module tb_spd_slave;
   localparam int HALF = 20;
   localparam int BUSY = 1000;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic       rst_n, scl, msda, wp;
   logic [2:0] strap;
   wire        pull, csum_ok;
   wire        line = msda & ~pull;

   spd_slave #(.BUSY_CLKS(BUSY)) dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(line), .strap_i(strap),
      .wp_i(wp), .sda_pull_o(pull), .csum_ok_o(csum_ok));

   int n_chk = 0, n_fail = 0, settle = 0;
   logic [7:0] ref_mem [256];
   int ref_ptr = 0;
   logic [7:0] wq [$];
   bit glitch = 1'b0;

   function automatic logic [7:0] img(input int k);
      logic [7:0] s;
      if (k < 63) return 8'((37 * k + 11) % 256);
      if (k == 63) begin
         s = 0;
         for (int j = 0; j < 63; j++) s = s + 8'((37 * j + 11) % 256);
         return s;
      end
      return 8'(k) ^ 8'hA5;
   endfunction

   function automatic bit ref_csum_good();
      logic [7:0] s = 0;
      for (int j = 0; j < 63; j++) s = s + ref_mem[j];
      return s == ref_mem[63];
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   // R11 reference: flag compared every clock once the model has settled
   always @(negedge clk) begin
      if (!rst_n) settle = 0;
      else begin
         settle++;
         if (settle >= 150) begin
            n_chk++;
            if (csum_ok !== ref_csum_good()) begin
               n_fail++;
               $display("FAIL R11 per-clock: actual %0b expected %0b", csum_ok, ref_csum_good());
            end
         end
      end
   end

   task automatic send_bit(input bit b, input bit g);
      tick(12); msda = b;
      if (g) begin tick(2); scl = 1'b1; tick(1); scl = 1'b0; tick(HALF - 15); end
      else tick(HALF - 12);
      scl = 1'b1;
      if (g && b) begin tick(5); msda = 1'b0; tick(1); msda = 1'b1; tick(HALF - 6); end
      else tick(HALF);
      scl = 1'b0;
   endtask

   task automatic get_bit(output bit v);
      bit v2;
      tick(12); msda = 1'b1; tick(HALF - 12);
      scl = 1'b1; tick(12); v = line;
      tick(HALF - 13); v2 = line;
      chk(v == v2, "R3 line stable while clock high", v2, v);
      tick(1); scl = 1'b0;
   endtask

   task automatic start_c();
      tick(12); msda = 1'b1; tick(HALF - 12); scl = 1'b1; tick(HALF);
      msda = 1'b0; tick(HALF); scl = 1'b0;
   endtask

   task automatic stop_c();
      tick(12); msda = 1'b0; tick(HALF - 12); scl = 1'b1; tick(HALF);
      msda = 1'b1; tick(HALF);
   endtask

   task automatic send_byte(input logic [7:0] b, input bit g, output bit ack);
      bit v;
      for (int i = 7; i >= 0; i--) send_bit(b[i], g && i == 6);
      get_bit(v);
      ack = !v;
   endtask

   task automatic recv_byte(output logic [7:0] b, input bit mack);
      bit v;
      for (int i = 7; i >= 0; i--) begin get_bit(v); b[i] = v; end
      send_bit(!mack, 1'b0);
   endtask

   function automatic logic [7:0] dev(input bit rd);
      return {4'b1010, strap, rd};
   endfunction

   task automatic rd_seq(input int n, input string tag);
      logic [7:0] v;
      for (int i = 0; i < n; i++) begin
         recv_byte(v, i < n - 1);
         chk(v == ref_mem[ref_ptr], tag, v, ref_mem[ref_ptr]);
         ref_ptr = (ref_ptr + 1) % 256;
      end
   endtask

   task automatic rand_rd(input logic [7:0] a, input int n, input string tag);
      bit ack;
      start_c();
      send_byte(dev(0), 0, ack); chk(ack, "R1 address ack", ack, 1);
      send_byte(a, 0, ack);      chk(ack, "R5 word address ack", ack, 1);
      start_c();
      send_byte(dev(1), 0, ack); chk(ack, "R5 read address ack", ack, 1);
      ref_ptr = a;
      rd_seq(n, tag);
      stop_c();
   endtask

   task automatic cur_rd(input int n, input string tag);
      bit ack;
      start_c();
      send_byte(dev(1), 0, ack); chk(ack, "R4 read address ack", ack, 1);
      rd_seq(n, tag);
      stop_c();
   endtask

   task automatic wr(input logic [7:0] a, input bit g);
      bit ack;
      start_c();
      send_byte(dev(0), 0, ack); chk(ack, "R1 address ack", ack, 1);
      send_byte(a, 0, ack);      chk(ack, "R2 word address ack", ack, 1);
      ref_ptr = a;
      for (int i = 0; i < wq.size(); i++) begin
         send_byte(wq[i], g && i == 0, ack);
         chk(ack, wp ? "R8 protected byte ack" : "R2 data ack", ack, 1);
         if (!wp) begin ref_mem[ref_ptr] = wq[i]; settle = 0; end
         ref_ptr = (ref_ptr + 1) % 256;
      end
      stop_c();
   endtask

   task automatic ignored_addr(input logic [7:0] b, input string tag);
      bit ack, v;
      start_c();
      send_byte(b, 0, ack); chk(!ack, tag, ack, 0);
      for (int i = 0; i < 9; i++) begin get_bit(v); chk(v, "R1 ignored after mismatch", v, 1); end
      stop_c();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      bit ack, v;
      logic [7:0] b;
      rst_n = 0; scl = 1; msda = 1; wp = 0; strap = 3'b101;
      for (int k = 0; k < 256; k++) ref_mem[k] = img(k);
      tick(5); rst_n = 1; tick(2);
      chk(csum_ok == 0, "R11 flag low after reset", csum_ok, 0);
      chk(pull == 0, "R3 released after reset", pull, 0);
      tick(100);
      chk(csum_ok == 1, "R11 flag after first scan", csum_ok, 1);

      rand_rd(8'h05, 3, "R10 boot image via R5 random read");
      cur_rd(2, "R4 current address read");
      ignored_addr({4'b1010, strap ^ 3'b010, 1'b1}, "R1 strap mismatch nack");
      ignored_addr({4'b1011, strap, 1'b1}, "R1 type mismatch nack");
      cur_rd(1, "R4 pointer kept across ignored transfers");

      // R7: master declines, slave must stay off the line
      start_c();
      send_byte(dev(1), 0, ack); chk(ack, "R7 read address ack", ack, 1);
      recv_byte(b, 0); chk(b == ref_mem[ref_ptr], "R7 single byte", b, ref_mem[ref_ptr]);
      ref_ptr = (ref_ptr + 1) % 256;
      for (int i = 0; i < 9; i++) begin get_bit(v); chk(v, "R7 silent after nack", v, 1); end
      stop_c();
      cur_rd(1, "R4 pointer after declined read");

      // R2 + R9
      wq = '{8'h11, 8'h22, 8'h33};
      wr(8'h40, 0);
      start_c();
      send_byte(dev(1), 0, ack); chk(!ack, "R9 busy after store", ack, 0);
      stop_c();
      tick(BUSY + 200);
      rand_rd(8'h40, 3, "R2 stored bytes read back");

      // R8: no store, no busy time
      wp = 1; wq = '{8'hAA, 8'hBB};
      wr(8'h50, 0);
      wp = 0;
      rand_rd(8'h50, 2, "R8 protected bytes unchanged");

      // R11: corrupt then repair byte 10
      wq = '{img(10) ^ 8'h01};
      wr(8'h0A, 0); tick(BUSY + 200);
      chk(csum_ok == 0, "R11 flag drops on bad sum", csum_ok, 0);
      wq = '{img(10)};
      wr(8'h0A, 0); tick(BUSY + 200);
      chk(csum_ok == 1, "R11 flag restored", csum_ok, 1);

      // R6 wrap
      rand_rd(8'hFB, 8, "R6 sequential read across 255");
      cur_rd(1, "R4 pointer after wrap");

      // R12 glitches in a stored byte (bit 6 of 8'h5C is 1)
      wq = '{8'h5C, 8'h3E};
      wr(8'h80, 1); tick(BUSY + 200);
      rand_rd(8'h80, 2, "R12 glitched write intact");

      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule